// File: doc/BRIEF.md
# Multicast hash address filter

This block sits on the receive side of an Ethernet MAC. It decides whether to accept a frame from its destination address. The destination address arrives one byte per cycle, first byte first, as the frame comes in. While the bytes arrive, the block runs a CRC over them and keeps two running checks: one for an exact match against the station's own address, and one for the all-ones broadcast address. One cycle after the sixth byte is taken, it raises a one-cycle decision strobe together with an accept bit and the six-bit hash index it used.

Multicast destinations go through a 64-bit hash bitmap. Software loads the bitmap through two 32-bit write ports. Each multicast address maps to one bit of the bitmap, and the address is accepted if software has set that bit. Unicast destinations skip the bitmap and are accepted only on an exact match. Broadcast is always accepted.

A frame-start pulse clears the CRC state and the match state. Any bytes after the sixth are ignored until the next frame start.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash CRC starts from all ones and uses polynomial 0x04C11DB7. For each byte, it consumes bit 0 first, one bit per step, with feedback equal to CRC bit 31 XOR the data bit. The final value is inverted, and its bits 31:26 are `hash_index`. That value appears on `hash_index` with the decision.
- R2: For a multicast address, `hash_index[5]` selects the table word: 1 selects the high word, 0 selects the low word. `hash_index[4:0]` selects a bit inside that word. The address is accepted exactly when that bit is 1.
- R3: After reset both table words are zero, so every multicast address other than broadcast is rejected.
- R4: A pulse on `table_lo_we` loads `table_wdata` into the low word, and a pulse on `table_hi_we` loads it into the high word. The lookup uses the word contents as they stood before the edge on which the sixth byte is taken, so a write on that same edge has no effect on that decision.
- R5: An address is multicast when bit 0 of its first byte is 1. The bit 0 of any other byte plays no part in this.
- R6: A unicast address is accepted only when every byte equals the station address, with byte i held in `station_addr[8*i+7:8*i]`. The table contents have no effect on a unicast decision.
- R7: The address with all 48 bits set is accepted whatever the table holds.
- R8: `decide_valid` is high for exactly one cycle, the cycle after the sixth address byte is taken. `accept` is 0 whenever `decide_valid` is 0.
- R9: `frame_start` clears the byte count and the CRC state. A byte presented in the same cycle as `frame_start` counts as the first byte. Bytes after the sixth produce no further decision until the next `frame_start`.
- R10: `hash_index` changes only in a cycle where `decide_valid` is high, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Marks the start of a new destination address |
| byte_valid | input | 1 | `byte_data` carries an address byte this cycle |
| byte_data | input | 8 | Address byte, first byte of the address first |
| station_addr | input | 48 | Station unicast address, byte i at bits 8i+7:8i |
| table_lo_we | input | 1 | Load low table word (bitmap bits 31:0) |
| table_hi_we | input | 1 | Load high table word (bitmap bits 63:32) |
| table_wdata | input | 32 | Data for table word loads |
| decide_valid | output | 1 | One-cycle strobe marking a decision |
| accept | output | 1 | Frame accepted; valid with `decide_valid` |
| hash_index | output | 6 | Hash index of the last decided address |

## Verification
The hardest case to reach from the ports is a multicast address whose index lands on a chosen bit in a chosen table word. Random addresses only rarely line up with a lone set bit. To reach it, the bench draws addresses, runs its own bit-serial hash on each, and keeps one whose index falls in the word it wants. It then loads a single bit into that word, or into the other word, so that both a hit and a near miss are seen. A second awkward case is a table load on the very edge that takes the sixth byte. The send task puts that load exactly on the last byte, and the reference model applies the load only after it has made the lookup.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C1_1DB7,
  parameter logic [31:0] CRC_INIT   = 32'hFFFF_FFFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic                    table_lo_we,
  input  logic                    table_hi_we,
  input  logic [31:0]             table_wdata,
  output logic                    decide_valid,
  output logic                    accept,
  output logic [5:0]              hash_index
);

  localparam int               CNT_W    = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] byte_cnt, cnt_base;
  logic [31:0]      crc_q, crc_base, crc_nxt, crc_fin;
  logic [31:0]      table_lo, table_hi, hash_word;
  logic             ucast_q, bcast_q, mcast_q;
  logic             ucast_nxt, bcast_nxt, mcast_nxt;
  logic             take, last, hit, verdict;
  logic [7:0]       stn_byte;
  logic [5:0]       idx_nxt;

  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int j = 0; j < 8; j++) begin
      if (c[31] ^ d[j]) c = {c[30:0], 1'b0} ^ CRC_POLY;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

  assign cnt_base = frame_start ? '0 : byte_cnt;
  assign crc_base = frame_start ? CRC_INIT : crc_q;
  assign take     = byte_valid && (cnt_base != CNT_FULL);
  assign last     = take && (cnt_base == CNT_LAST);

  always_comb begin
    stn_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt_base == CNT_W'(i)) stn_byte = station_addr[8*i +: 8];
  end

  assign ucast_nxt = (frame_start || ucast_q) && (byte_data == stn_byte);
  assign bcast_nxt = (frame_start || bcast_q) && (&byte_data);
  assign mcast_nxt = (cnt_base == '0) ? byte_data[0] : mcast_q;
  assign crc_nxt   = crc_byte(crc_base, byte_data);
  assign crc_fin   = ~crc_nxt;
  assign idx_nxt   = crc_fin[31:26];
  assign hash_word = idx_nxt[5] ? table_hi : table_lo;
  assign hit       = hash_word[idx_nxt[4:0]];
  assign verdict   = bcast_nxt | (mcast_nxt ? hit : ucast_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_cnt <= '0;
      crc_q    <= CRC_INIT;
      ucast_q  <= 1'b1;
      bcast_q  <= 1'b1;
      mcast_q  <= 1'b0;
    end else if (take) begin
      byte_cnt <= cnt_base + CNT_W'(1);
      crc_q    <= crc_nxt;
      ucast_q  <= ucast_nxt;
      bcast_q  <= bcast_nxt;
      mcast_q  <= mcast_nxt;
    end else if (frame_start) begin
      byte_cnt <= '0;
      crc_q    <= CRC_INIT;
      ucast_q  <= 1'b1;
      bcast_q  <= 1'b1;
      mcast_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      table_lo <= '0;
      table_hi <= '0;
    end else begin
      if (table_lo_we) table_lo <= table_wdata;
      if (table_hi_we) table_hi <= table_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decide_valid <= 1'b0;
      accept       <= 1'b0;
      hash_index   <= '0;
    end else begin
      decide_valid <= last;
      accept       <= last && verdict;
      if (last) hash_index <= idx_nxt;
    end
  end

endmodule

module mcast_hash_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_valid,
  input logic       decide_valid,
  input logic       accept,
  input logic [5:0] hash_index
);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    decide_valid |=> !decide_valid);

  assert_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    decide_valid |-> $past(byte_valid));

  assert_accept_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !decide_valid |-> !accept);

  assert_index_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hash_index) |-> decide_valid);

endmodule

bind mcast_hash_filter mcast_hash_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
  .decide_valid(decide_valid), .accept(accept), .hash_index(hash_index)
);

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;

  localparam logic [47:0] STN = 48'h5E_4D_3C_2B_1A_02;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        table_lo_we = 1'b0;
  logic        table_hi_we = 1'b0;
  logic [31:0] table_wdata = '0;
  logic        decide_valid, accept;
  logic [5:0]  hash_index;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  string acc_tag = "R3";

  always #10 clk = ~clk;

  mcast_hash_filter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .station_addr(STN), .table_lo_we(table_lo_we),
    .table_hi_we(table_hi_we), .table_wdata(table_wdata),
    .decide_valid(decide_valid), .accept(accept), .hash_index(hash_index)
  );

  function automatic logic [5:0] idx_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 8; j++) begin
        if (c[31] ^ a[8*i+j]) c = (c << 1) ^ 32'h04C1_1DB7;
        else                  c = c << 1;
      end
    c = ~c;
    return c[31:26];
  endfunction

  // reference model: expected outputs after each rising edge
  logic [7:0]  mq[$];
  logic [31:0] m_lo = '0, m_hi = '0;
  logic        e_valid = 1'b0, e_acc = 1'b0;
  logic [5:0]  e_idx = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_lo = '0; m_hi = '0;
      e_valid = 1'b0; e_acc = 1'b0; e_idx = '0;
    end else begin
      e_valid = 1'b0; e_acc = 1'b0;
      if (frame_start) mq.delete();
      if (byte_valid && mq.size() < 6) begin
        mq.push_back(byte_data);
        if (mq.size() == 6) begin
          logic [47:0] a;
          logic [63:0] bm;
          for (int i = 0; i < 6; i++) a[8*i +: 8] = mq[i];
          e_idx = idx_of(a);
          e_valid = 1'b1;
          bm = {m_hi, m_lo};
          if (&a)       e_acc = 1'b1;
          else if (a[0]) e_acc = bm[e_idx];
          else          e_acc = (a == STN);
        end
      end
      if (table_lo_we) m_lo = table_wdata;
      if (table_hi_we) m_hi = table_wdata;
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_vec++;
      if (decide_valid !== e_valid) begin
        n_bad++;
        $display("FAIL R8 decide_valid=%0b expected %0b at %0t", decide_valid, e_valid, $time);
      end
      if (accept !== e_acc) begin
        n_bad++;
        $display("FAIL %s accept=%0b expected %0b at %0t", acc_tag, accept, e_acc, $time);
      end
      if (hash_index !== e_idx) begin
        n_bad++;
        $display("FAIL R1 R10 hash_index=%0d expected %0d at %0t", hash_index, e_idx, $time);
      end
    end
  end

  task automatic wr_table(input bit hi, input logic [31:0] v);
    @(negedge clk);
    table_lo_we = !hi; table_hi_we = hi; table_wdata = v;
    @(negedge clk);
    table_lo_we = 1'b0; table_hi_we = 1'b0;
  endtask

  task automatic send(input logic [47:0] a, input bit gap, input bit wr_last,
                      input logic [31:0] wv, input int extra);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      frame_start = (i == 0); byte_valid = 1'b1; byte_data = a[8*i +: 8];
      table_hi_we = wr_last && (i == 5); table_wdata = wv;
      if (gap && i < 5) begin
        @(negedge clk);
        frame_start = 1'b0; byte_valid = 1'b0; table_hi_we = 1'b0;
      end
    end
    for (int k = 0; k < extra; k++) begin
      @(negedge clk);
      frame_start = 1'b0; byte_valid = 1'b1; byte_data = 8'($urandom); table_hi_we = 1'b0;
    end
    @(negedge clk);
    frame_start = 1'b0; byte_valid = 1'b0; table_hi_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [47:0] rnd_mcast(input int want_hi);
    logic [47:0] a;
    logic [5:0]  ix;
    do begin
      a = {16'($urandom), $urandom};
      a[0] = 1'b1;
      ix = idx_of(a);
    end while ((&a) || (want_hi >= 0 && int'(ix[5]) != want_hi));
    return a;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    acc_tag = "R3";
    for (int n = 0; n < 8; n++) send(rnd_mcast(-1), 1'b0, 1'b0, '0, 0);

    acc_tag = "R7";
    send({48{1'b1}}, 1'b0, 1'b0, '0, 0);

    acc_tag = "R6";
    send(STN, 1'b0, 1'b0, '0, 0);
    send(STN ^ 48'h01_00_00_00_00_00, 1'b0, 1'b0, '0, 0);
    send(STN ^ 48'h00_00_00_00_00_04, 1'b1, 1'b0, '0, 0);
    wr_table(1'b0, 32'hFFFF_FFFF);
    wr_table(1'b1, 32'hFFFF_FFFF);
    send(STN ^ 48'h00_00_10_00_00_00, 1'b0, 1'b0, '0, 0);
    send(STN, 1'b0, 1'b0, '0, 0);

    acc_tag = "R5";
    send(48'h00_00_00_00_00_01, 1'b0, 1'b0, '0, 0);
    send(48'h01_01_01_01_01_00, 1'b0, 1'b0, '0, 0);

    acc_tag = "R2";
    for (int n = 0; n < 40; n++) begin
      if (n % 8 == 0) begin
        wr_table(1'b0, $urandom);
        wr_table(1'b1, $urandom);
      end
      send(rnd_mcast(-1), n[0], 1'b0, '0, 0);
    end
    for (int h = 0; h < 2; h++) begin
      logic [47:0] a = rnd_mcast(h);
      logic [5:0]  ix = idx_of(a);
      wr_table(h[0], 32'(1) << ix[4:0]);
      wr_table(!h[0], '0);
      send(a, 1'b0, 1'b0, '0, 0);
      wr_table(h[0], '0);
      wr_table(!h[0], 32'(1) << ix[4:0]);
      send(a, 1'b0, 1'b0, '0, 0);
    end

    acc_tag = "R4";
    for (int n = 0; n < 4; n++) begin
      logic [47:0] a = rnd_mcast(1);
      wr_table(1'b1, (n % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF);
      send(a, 1'b0, 1'b1, (n % 2 == 0) ? 32'hFFFF_FFFF : 32'h0, 0);
      send(a, 1'b0, 1'b0, '0, 0);
    end

    acc_tag = "R9";
    wr_table(1'b0, $urandom);
    wr_table(1'b1, $urandom);
    send(rnd_mcast(-1), 1'b0, 1'b0, '0, 5);
    send(STN, 1'b1, 1'b0, '0, 3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      frame_start = (k == 0); byte_valid = 1'b1; byte_data = 8'hA5;
    end
    send(STN, 1'b0, 1'b0, '0, 0);
    send(rnd_mcast(-1), 1'b0, 1'b0, '0, 0);

    acc_tag = "R3";
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    for (int n = 0; n < 4; n++) send(rnd_mcast(-1), 1'b0, 1'b0, '0, 0);
    send({48{1'b1}}, 1'b0, 1'b0, '0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R8 watchdog expired: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule